// File: doc/BRIEF.md
# Sticky Interrupt Status Flag Register

This block holds the 8-bit status word of a real-time-clock style device. Five single-cycle event pulses feed it: a time-update tick, a fixed-cycle timer expiry, an alarm match, a data-loss (voltage low) indication and a voltage-detect indication. Each one sets its own flag bit. The bit then stays at 1 until software writes a 0 to that position. Three bit positions are reserved. They ignore writes and always read as zero.

Software reaches the register over a simple synchronous bus with a write strobe, a read strobe, a shared address and write data. Read data comes back registered. The word answers at two bus addresses, and both lead to the same storage. A registered, active-low interrupt line goes low while any of the update, timer or alarm flags is set and the enable input for that flag is high. The data-loss flag comes out of reset set, so that software can tell that the stored time cannot be trusted.

Top module: `rtc_irq_flags`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the flag image is 0x02 (data-loss flag set, all others clear) and `irq_n` is 1.
- R2: An event pulse sets its flag on the next clock edge, and the flag stays 1 from then on until it is cleared. Bit positions: update = bit 5, timer = bit 4, alarm = bit 3, data-loss = bit 1, voltage-detect = bit 0.
- R3: A write that hits the register clears every flag whose write-data bit is 0. A flag whose write-data bit is 1 keeps its value.
- R4: When an event and a clearing write reach the same flag in the same cycle, the flag is 1 after the edge.
- R5: Bits 7, 6 and 2 always read 0, whatever value is written to them.
- R6: Addresses 0x0E and 0x1E reach the same storage. A write to any other address changes no flag, and a read of any other address returns 0x00.
- R7: `irq_n` is 0 in the cycle after a cycle in which (update & `en_update`) | (timer & `en_timer`) | (alarm & `en_alarm`) is true, and 1 otherwise. The data-loss and voltage-detect flags never drive it.
- R8: `rd_data` loads on a clock edge at which `rd_en` is high. It holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| addr | input | 5 | Bus address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears the matching flag |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| ev_update | input | 1 | Time-update event pulse |
| ev_timer | input | 1 | Fixed-cycle timer event pulse |
| ev_alarm | input | 1 | Alarm match event pulse |
| ev_vlow | input | 1 | Data-loss / voltage-low event pulse |
| ev_vdet | input | 1 | Voltage-detect event pulse |
| en_update | input | 1 | Interrupt enable for the update flag |
| en_timer | input | 1 | Interrupt enable for the timer flag |
| en_alarm | input | 1 | Interrupt enable for the alarm flag |
| irq_n | output | 1 | Registered active-low combined interrupt |

## Verification
The collision that matters is a clearing write landing on a flag in the same cycle that its event pulse arrives. In that case the set must win. The bench raises the timer pulse in the same cycle as a write of 0x00 to the register. It then predicts that only the timer bit survives and checks this through a later bus read. The bench also raises a read strobe in the same cycle as an event and expects the read to return the image from before the event.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned POS_UPD  = 5;
  localparam int unsigned POS_TMR  = 4;
  localparam int unsigned POS_ALM  = 3;
  localparam int unsigned POS_VLOW = 1;
  localparam int unsigned POS_VDET = 0;
  localparam logic [FLAG_W-1:0] LIVE_MASK =
    FLAG_W'((1 << POS_UPD) | (1 << POS_TMR) | (1 << POS_ALM) | (1 << POS_VLOW) | (1 << POS_VDET));
  localparam logic [FLAG_W-1:0] RST_IMAGE = FLAG_W'(1 << POS_VLOW);
  localparam logic [FLAG_W-1:0] IRQ_MASK =
    FLAG_W'((1 << POS_UPD) | (1 << POS_TMR) | (1 << POS_ALM));
endpackage

// File: rtl/rtc_flag_addr_match.sv
module rtc_flag_addr_match #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ADDR_A = 5'h0E,
  parameter int unsigned ADDR_B = 5'h1E
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] A_LOC = ADDR_W'(ADDR_A);
  localparam logic [ADDR_W-1:0] B_LOC = ADDR_W'(ADDR_B);

  always_comb hit = (addr == A_LOC) || (addr == B_LOC);
endmodule

// File: rtl/rtc_flag_cell.sv
module rtc_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic ev,
  input  logic wr_hit,
  input  logic wr_bit,
  output logic q
);
  logic clr;
  always_comb clr = wr_hit && !wr_bit;

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (ev)  q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst) ev |=> q);
  p_sticky_r2: assert property (@(posedge clk) disable iff (rst) (q && !clr) |=> q);
  p_clear_r3: assert property (@(posedge clk) disable iff (rst) (clr && !ev) |=> !q);
  p_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_bit && !ev) |=> (q == $past(q)));
  p_collide_r4: assert property (@(posedge clk) disable iff (rst) (ev && clr) |=> q);
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
  import rtc_flag_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned ADDR_A = 5'h0E,
  parameter int unsigned ADDR_B = 5'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [FLAG_W-1:0] rd_data,
  input  logic              ev_update,
  input  logic              ev_timer,
  input  logic              ev_alarm,
  input  logic              ev_vlow,
  input  logic              ev_vdet,
  input  logic              en_update,
  input  logic              en_timer,
  input  logic              en_alarm,
  output logic              irq_n
);
  logic              addr_hit;
  logic              wr_hit;
  logic [FLAG_W-1:0] ev_vec;
  logic [FLAG_W-1:0] en_vec;
  logic [FLAG_W-1:0] flag_img;

  rtc_flag_addr_match #(.ADDR_W(ADDR_W), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B)) u_match (
    .addr(addr), .hit(addr_hit)
  );

  always_comb begin
    wr_hit = wr_en && addr_hit;
    ev_vec = '0;
    ev_vec[POS_UPD]  = ev_update;
    ev_vec[POS_TMR]  = ev_timer;
    ev_vec[POS_ALM]  = ev_alarm;
    ev_vec[POS_VLOW] = ev_vlow;
    ev_vec[POS_VDET] = ev_vdet;
    en_vec = '0;
    en_vec[POS_UPD] = en_update;
    en_vec[POS_TMR] = en_timer;
    en_vec[POS_ALM] = en_alarm;
  end

  for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
    if (LIVE_MASK[i]) begin : g_live
      rtc_flag_cell #(.RST_VAL(RST_IMAGE[i])) u_cell (
        .clk(clk), .rst(rst), .ev(ev_vec[i]), .wr_hit(wr_hit),
        .wr_bit(wr_data[i]), .q(flag_img[i])
      );
    end else begin : g_rsvd
      assign flag_img[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq_n   <= 1'b1;
    end else begin
      if (rd_en) rd_data <= addr_hit ? flag_img : '0;
      irq_n <= ~|(flag_img & en_vec & IRQ_MASK);
    end
  end

  p_rsvd_r5: assert property (@(posedge clk) disable iff (rst) (rd_data & ~LIVE_MASK) == '0);
  p_irq_on_r7: assert property (@(posedge clk) disable iff (rst)
    (|(flag_img & en_vec & IRQ_MASK)) |=> !irq_n);
  p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
    !(|(flag_img & en_vec & IRQ_MASK)) |=> irq_n);
  p_miss_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr_hit && ev_vec == '0) |=> $stable(flag_img));
  p_hold_r8: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rd_data));
endmodule

// File: tb/rtc_irq_flags_tb.sv
module rtc_irq_flags_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       ev_update = 0, ev_timer = 0, ev_alarm = 0, ev_vlow = 0, ev_vdet = 0;
  logic       en_update = 0, en_timer = 0, en_alarm = 0;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  logic [7:0] held;

  always #2.5 clk = ~clk;

  rtc_irq_flags u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .ev_update(ev_update), .ev_timer(ev_timer),
    .ev_alarm(ev_alarm), .ev_vlow(ev_vlow), .ev_vdet(ev_vdet), .en_update(en_update),
    .en_timer(en_timer), .en_alarm(en_alarm), .irq_n(irq_n)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // driver: issue a read and push the expected word
  task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    step();
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  // monitor: compare registered read data one edge after the strobe
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(rd_data, e, t);
    end
  end

  initial begin
    #(5 * 20000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    check({7'd0, irq_n}, 8'h01, "R1 irq_n idle in reset");
    rst = 1'b0;
    rd(5'h0E, 8'h02, "R1 reset image");
    check({7'd0, irq_n}, 8'h01, "R1 irq_n after reset");
    wr(5'h0E, 8'h00);
    rd(5'h0E, 8'h00, "R3 write zero clears data-loss");
    wr(5'h0E, 8'hFF);
    rd(5'h0E, 8'h00, "R5 reserved ignore ones");
    ev_update = 1'b1; step(); ev_update = 1'b0;
    step();
    check({7'd0, irq_n}, 8'h01, "R7 disabled update no irq");
    rd(5'h1E, 8'h20, "R2 update bit5 via alt addr R6");
    en_update = 1'b1; step(); step();
    check({7'd0, irq_n}, 8'h00, "R7 enabled update irq");
    ev_timer = 1; ev_alarm = 1; ev_vlow = 1; ev_vdet = 1; step();
    ev_timer = 0; ev_alarm = 0; ev_vlow = 0; ev_vdet = 0;
    repeat (3) step();
    rd(5'h0E, 8'h3B, "R2 all events sticky");
    wr(5'h0E, 8'hFF);
    rd(5'h1E, 8'h3B, "R3 write ones keep flags");
    wr(5'h0F, 8'h00);
    rd(5'h0F, 8'h00, "R6 miss address reads zero");
    rd(5'h0E, 8'h3B, "R6 miss address write ignored");
    wr(5'h1E, 8'hDF);
    rd(5'h0E, 8'h1B, "R3 clear update only via alt addr");
    // R4: clear-all write and timer event in the same cycle
    addr = 5'h0E; wr_data = 8'h00; wr_en = 1'b1; ev_timer = 1'b1;
    step();
    wr_en = 1'b0; ev_timer = 1'b0;
    rd(5'h0E, 8'h10, "R4 event wins over clear");
    en_update = 0; en_timer = 0; en_alarm = 1;
    step(); step();
    check({7'd0, irq_n}, 8'h01, "R7 timer disabled no irq");
    en_timer = 1; step(); step();
    check({7'd0, irq_n}, 8'h00, "R7 timer enabled irq");
    wr(5'h0E, 8'h00);
    ev_vlow = 1; step(); ev_vlow = 0;
    step();
    check({7'd0, irq_n}, 8'h01, "R7 data-loss never interrupts");
    // R8: read strobe and event share a cycle; old image returned, then held
    addr = 5'h0E; rd_en = 1'b1; ev_alarm = 1'b1;
    exp_q.push_back(8'h02); tag_q.push_back("R8 read captures pre-event image");
    step();
    rd_en = 1'b0; ev_alarm = 1'b0;
    held = rd_data;
    step(); step();
    check(rd_data, held, "R8 rd_data holds without strobe");
    rd(5'h0E, 8'h0A, "R2 alarm bit3 after collision read");
    step();
    check({7'd0, irq_n}, 8'h00, "R7 alarm enabled irq");
    step();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule